// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a supervisory watchdog. It counts millisecond ticks toward a timeout chosen by a 3-bit period code. Each low-to-high edge on the kick line starts a new period. When the count reaches the chosen length, the block issues a one-clock timeout request to the reset controller and sets a sticky timed-out flag that status logic can read.

A kick line that sits at either level gives no edges, so the count keeps running out. In that case the watchdog free-runs and requests a reset once per period. The reset controller feeds back a level that is high while its reset outputs are asserted. While that level is high the counter is held at zero. When the level falls, a complete new period begins. Changing the period code also starts a new period.

The base period is a parameter counted in ticks, and each higher code doubles it. A deployment with a 1 ms tick and a base of 400 gives 400 ms, 800 ms, 1.6 s, 3.2 s and 6.4 s.

Top module: `kick_watchdog`

## Requirements
- R1: While `rst_n` is low at a clock edge, `expire_o` and `expired_o` are 0 after that edge.
- R2: Period code 3'b011 selects BASE_TICKS ticks, and each step up to 3'b111 doubles the length (3'b100 = 2x, 3'b101 = 4x, 3'b110 = 8x, 3'b111 = 16x). Codes 3'b000, 3'b001 and 3'b010 disable the watchdog: the counter stays at zero and `expire_o` never rises.
- R3: Let a restart take effect at clock edge R, with a period of L ticks and a tick present at every later edge. Then `expire_o` is high for exactly one clock after edge R+L.
- R4: The kick line passes through two synchronizer flops. Suppose `kick_i` is first sampled high at edge n after being low. The counter then restarts at edge n+2.
- R5: If `kick_i` is held high or held low, it does not prevent a timeout. The watchdog then free-runs and raises `expire_o` once every L ticks.
- R6: While `resets_active_i` is high, the counter is held at zero and `expire_o` stays low. If edge r is the last edge that samples it high, the next timeout follows edge r+L.
- R7: A change of `period_code_i` restarts the counter at the edge that first samples the new code. The next timeout is then measured in the new period.
- R8: The counter advances only at edges where `tick_i` is high. Without ticks, no timeout occurs.
- R9: `expired_o` rises together with `expire_o`, stays high after the pulse, and is cleared at the edge where a kick restart takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-clock time-base pulse (one per millisecond) |
| kick_i | input | 1 | Asynchronous kick line; a rising edge restarts the period |
| period_code_i | input | 3 | Timeout period selector |
| resets_active_i | input | 1 | High while the reset controller holds its outputs asserted |
| expire_o | output | 1 | One-clock timeout request to the reset controller |
| expired_o | output | 1 | Sticky flag: a timeout occurred since the last kick |

## Verification
The hardest case to reach from the ports is an expiry that is suppressed: a timeout that would have fired under the old conditions but must not, because the period code changed or reset feedback arrived just beforehand.

The stimulus reaches this case by arming a period and then, part-way through, either switching to a longer code or raising the feedback right after an expiry. The scoreboard holds only the newly computed expiry cycle. Any pulse at the old cycle is therefore reported as unexpected.

Kicks are placed a few cycles before the period would run out, so the two-flop synchronizer latency decides whether the timeout happens.

// File: rtl/kwd_pkg.sv
// Shared constants and types for the kick watchdog.
// Assumes codes below FIRST_ON_CODE mean "off" and each code above it doubles the period.
package kwd_pkg;
    localparam int CODE_W        = 3;
    localparam int FIRST_ON_CODE = 3;
    localparam int SHIFT_MAX     = 4;
    typedef logic [CODE_W-1:0] period_code_t;
endpackage

// File: rtl/kwd_kick_sync.sv
// Synchronizes the asynchronous kick line and flags its rising edges.
// Assumes the line idles high; flops reset to 1 so a high line at reset is no edge.
module kwd_kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    output logic kick_rise_o
);
    logic [STAGES:0] chain;

    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // first capture flop of the async kick line
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= kick_i;
            end
        end else begin : g_next
            // further synchronizer stage; the last one keeps the previous value
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b1;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    // rising edge seen on the synchronized value
    assign kick_rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/kwd_period_sel.sv
// Decodes the period code into an enable and a tick-count limit.
// Assumes BASE_TICKS * 2**SHIFT_MAX fits in CNT_W bits.
module kwd_period_sel
    import kwd_pkg::*;
#(
    parameter int BASE_TICKS = 400,
    parameter int CNT_W      = 13
) (
    input  period_code_t     code_i,
    output logic             enable_o,
    output logic [CNT_W-1:0] limit_o
);
    logic [CODE_W-1:0] shift;

    // map code to on/off and to base period doubled per step
    always_comb begin
        enable_o = (code_i >= CODE_W'(FIRST_ON_CODE));
        shift    = code_i - CODE_W'(FIRST_ON_CODE);
        limit_o  = enable_o ? (CNT_W'(BASE_TICKS) << shift) : '0;
    end
endmodule

// File: rtl/kwd_counter.sv
// Tick counter that wraps at the limit and emits a registered expiry pulse.
// Assumes limit_i >= 2 whenever restart_i is low.
module kwd_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             hit_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] count;
    logic             at_end;

    assign at_end = (count == (limit_i - CNT_W'(1)));
    assign hit_o  = tick_i & ~restart_i & at_end;

    // count ticks, clear on restart, wrap at the end of the period
    always_ff @(posedge clk) begin
        if (!rst_n)         count <= '0;
        else if (restart_i) count <= '0;
        else if (tick_i) begin
            if (at_end) count <= '0;
            else        count <= count + CNT_W'(1);
        end
    end

    // register the expiry as a one-clock request
    always_ff @(posedge clk) begin
        if (!rst_n) expire_o <= 1'b0;
        else        expire_o <= hit_o;
    end
endmodule

// File: rtl/kick_watchdog.sv
// Programmable watchdog: restarts on kick edges, code changes and reset feedback.
// Assumes tick_i is a one-clock pulse and resets_active_i is synchronous to clk.
module kick_watchdog
    import kwd_pkg::*;
#(
    parameter int BASE_TICKS = 400,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              kick_i,
    input  logic [CODE_W-1:0] period_code_i,
    input  logic              resets_active_i,
    output logic              expire_o,
    output logic              expired_o
);
    localparam int CNT_W = $clog2(BASE_TICKS * (1 << SHIFT_MAX) + 1);

    logic             kick_rise;
    logic             enable;
    logic [CNT_W-1:0] limit;
    period_code_t     code_q;
    logic             code_chg;
    logic             restart;
    logic             hit;

    kwd_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .kick_i      (kick_i),
        .kick_rise_o (kick_rise)
    );

    kwd_period_sel #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) u_sel (
        .code_i   (period_code_i),
        .enable_o (enable),
        .limit_o  (limit)
    );

    // remember the code so a change can restart the period
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= period_code_i;
    end

    assign code_chg = (period_code_i != code_q);
    assign restart  = kick_rise | code_chg | resets_active_i | ~enable;

    kwd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .restart_i (restart),
        .limit_i   (limit),
        .hit_o     (hit),
        .expire_o  (expire_o)
    );

    // sticky timeout flag, cleared by a kick restart
    always_ff @(posedge clk) begin
        if (!rst_n)         expired_o <= 1'b0;
        else if (hit)       expired_o <= 1'b1;
        else if (kick_rise) expired_o <= 1'b0;
    end
endmodule

// File: rtl/kwd_checker.sv
// Temporal checks for the kick watchdog, attached by bind.
// Assumes BASE_TICKS >= 2 so expiry pulses never abut.
module kwd_checker
    import kwd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic [CODE_W-1:0] period_code_i,
    input logic              resets_active_i,
    input logic              expire_o,
    input logic              expired_o,
    input logic              kick_rise
);
    // R3: request lasts a single clock
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);

    // R2: off codes never expire
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(period_code_i) < CODE_W'(FIRST_ON_CODE)) |-> !expire_o);

    // R6: feedback holds the timer
    p_hold_in_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(resets_active_i) |-> !expire_o);

    // R8: no tick, no progress to expiry
    p_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_i) |-> !expire_o);

    // R9: flag accompanies each pulse
    p_flag_with_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> expired_o);

    // R9: kick restart clears the flag
    p_kick_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(kick_rise) |-> !expired_o);
endmodule

bind kick_watchdog kwd_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick_i          (tick_i),
    .period_code_i   (period_code_i),
    .resets_active_i (resets_active_i),
    .expire_o        (expire_o),
    .expired_o       (expired_o),
    .kick_rise       (kick_rise)
);

// File: tb/kick_watchdog_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver pushes expected expiry cycles, monitor compares pulses.
module kick_watchdog_tb_top;
    localparam int BASE = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic       kick;
    logic [2:0] code;
    logic       active;
    logic       expire_o;
    logic       expired_o;

    int cyc    = 0;
    int checks = 0;
    int bad    = 0;
    int seen   = 0;
    bit done   = 1'b0;

    typedef struct { int at; string req; } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    kick_watchdog #(.BASE_TICKS(BASE)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick_i          (tick),
        .kick_i          (kick),
        .period_code_i   (code),
        .resets_active_i (active),
        .expire_o        (expire_o),
        .expired_o       (expired_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic push(input int at, input string req);
        exp_t e;
        e.at = at; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic go_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare each expiry pulse with the scoreboard
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            while (exp_q.size() > 0 && exp_q[0].at < cyc) begin
                check(1'b0, exp_q[0].req, 0, exp_q[0].at);
                void'(exp_q.pop_front());
            end
            if (expire_o) begin
                seen++;
                if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
                    check(1'b1, exp_q[0].req, cyc, cyc);
                    void'(exp_q.pop_front());
                end else begin
                    check(1'b0, "R3 unexpected pulse", cyc,
                          exp_q.size() > 0 ? exp_q[0].at : -1);
                end
            end
        end
    end

    initial begin
        int m;
        int s;
        rst_n = 1'b0; tick = 1'b1; kick = 1'b1; code = 3'd0; active = 1'b0;
        step(3);
        check(expire_o == 1'b0, "R1 expire", int'(expire_o), 0);
        check(expired_o == 1'b0, "R1 flag", int'(expired_o), 0);
        rst_n = 1'b1;
        step(2);

        // R5: kick stuck low, code 011, free-running
        m = cyc; kick = 1'b0; code = 3'd3;
        push(m + 5, "R2"); push(m + 9, "R5"); push(m + 13, "R5");
        go_to(m + 13); code = 3'd0;
        check(expired_o == 1'b1, "R9 set", int'(expired_o), 1);

        // R9: kick edge while off clears flag; R5 kick held high, code 100
        kick = 1'b1; step(5);
        check(expired_o == 1'b0, "R9 clear", int'(expired_o), 0);
        m = cyc; code = 3'd4;
        push(m + 9, "R2"); push(m + 17, "R5");
        go_to(m + 17); code = 3'd0;

        // R4: kicks inside the period postpone the timeout, code 101
        step(3); m = cyc; code = 3'd5;
        push(m + 44, "R4");
        go_to(m + 2);  kick = 1'b0;
        go_to(m + 10); kick = 1'b1;
        go_to(m + 14);
        check(expired_o == 1'b0, "R9 cleared by kick", int'(expired_o), 0);
        kick = 1'b0;
        go_to(m + 25); kick = 1'b1;
        go_to(m + 44);
        check(expired_o == 1'b1, "R9 set again", int'(expired_o), 1);
        code = 3'd0;

        // R6: reset feedback holds the counter
        step(3); m = cyc; code = 3'd3;
        push(m + 5, "R3");
        go_to(m + 5);  active = 1'b1;
        go_to(m + 15); active = 1'b0;
        push(m + 19, "R6");
        go_to(m + 19); code = 3'd0;

        // R7: code change restarts in the new period
        step(3); m = cyc; s = seen; code = 3'd6;
        go_to(m + 20); code = 3'd7;
        push(m + 85, "R7");
        go_to(m + 40);
        check(seen == s, "R7 old period suppressed", seen - s, 0);
        go_to(m + 85); code = 3'd0;

        // R2: unlisted codes are off
        step(3); s = seen; code = 3'd1;
        step(200); code = 3'd2;
        step(200); code = 3'd0;
        check(seen == s, "R2 off codes", seen - s, 0);

        // R8: counting waits for ticks
        step(3); m = cyc; code = 3'd3; tick = 1'b0;
        go_to(m + 20); tick = 1'b1;
        push(m + 24, "R8");
        go_to(m + 24); code = 3'd0;

        step(6);
        check(exp_q.size() == 0, "R3 pending expiries", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    // watchdog for a hung run
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; bad++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule